// File: doc/BRIEF.md
# Multi-line parallel SPI master shift engine

This block is a master-side serial shift engine. It moves one 16-bit word out over 1, 2, 4 or 8 parallel output lines, and at the same time collects a 16-bit word from the same number of input lines. The serial clock idles low. Outgoing data changes on its rising edge, and incoming data is captured on its falling edge. Words travel most significant bit first.

The word register is split into one equal segment per active line. Line k owns bits `[k*W+W-1 : k*W]`, where `W = 16/N` and N is the number of active lines. Each line is driven from the top bit of its segment, and each received bit enters at the bottom of its segment. A word therefore needs only W serial clock pulses, which is two pulses with eight lines. An optional extra pulse on line 0 carries an even-parity bit outward and checks the parity bit that comes back.

A control state machine sequences the frame through the following states:
- IDLE
- SETUP (clock low, first bits presented)
- HIGH
- LOW
- PLOW and PHIGH (the parity pulse)

The transitions are:
- IDLE→SETUP on a write.
- SETUP→HIGH on a divider tick.
- LOW→HIGH on a tick.
- HIGH→LOW on a tick while bits remain.
- HIGH→PLOW on the last tick when parity is on.
- HIGH→IDLE on the last tick when parity is off.
- PLOW→PHIGH on a tick.
- PHIGH→IDLE on a tick.

A clock divider produces a tick every `half_div+1` system clocks, and each tick ends one half period of the serial clock.

Top module: `mlspi_engine`

## Requirements
- R1: After reset, the following outputs are all 0: `sclk`, `dout_lines`, `busy`, `rx_data`, `rx_flag`, `ovr` and `perr`. While idle, `sclk` is 0 and `dout_lines` is all zero.
- R2: `lane_mode` encodes the line count as follows: 0 gives 1 line, 1 gives 2 lines, 2 gives 4 lines and 3 gives 8 lines. A frame has exactly 16/N rising edges of `sclk`, plus one more when parity is enabled.
- R3: At data rising edge j (0-based), output line k (k<N) carries transmit bit `k*W+W-1-j`, with W=16/N. Lines k≥N are driven 0.
- R4: The first bits of the word appear on `dout_lines` from the cycle after the write, before the first rising edge. During a frame, `dout_lines` holds steady while `sclk` stays high and while it stays low.
- R5: Input line k, sampled at the falling edge of data cycle j, ends up in bit `k*W+W-1-j` of `rx_data`.
- R6: Each high phase of `sclk` lasts exactly `half_div+1` system clock cycles.
- R7: At the end of a frame, `rx_data` is loaded and `rx_flag` is set. `rx_flag` stays set until `clr_rx` is pulsed, which clears both `rx_flag` and `ovr`.
- R8: `ovr` is set when a frame completes while `rx_flag` is still set.
- R9: With `par_en` set, the extra pulse drives line 0 with the XOR of the 16 transmit bits (even parity) and drives all other lines 0.
- R10: If the bit received on input line 0 during the parity pulse differs from the XOR of the 16 received bits, `perr` is set. `perr` is sticky until `clr_perr` is pulsed.
- R11: A write while `busy` is ignored. `lane_mode`, `par_en` and `half_div` are captured at the start of a frame, and later changes do not affect the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr | input | 1 | Write strobe; starts a frame when idle |
| tx_data | input | 16 | Word to transmit |
| lane_mode | input | 2 | Line-count select (1/2/4/8 lines) |
| par_en | input | 1 | Add a parity pulse on line 0 |
| half_div | input | 8 | Serial half period minus one, in system clocks |
| din_lines | input | 8 | Incoming data lines |
| clr_rx | input | 1 | Clears the receive flag and the overrun flag |
| clr_perr | input | 1 | Clears the parity error flag |
| sclk | output | 1 | Serial clock, idles low |
| dout_lines | output | 8 | Outgoing data lines |
| busy | output | 1 | A frame is in progress |
| rx_data | output | 16 | Last received word |
| rx_flag | output | 1 | A received word is ready |
| ovr | output | 1 | A word completed while the previous one was unread |
| perr | output | 1 | Sticky parity mismatch |

## Verification
A wrong segment boundary, a wrong shift direction or a missed shift shows up on `dout_lines` no later than the second rising edge of the frame. It also appears in `rx_data` as soon as the frame ends. A miscounted bit counter changes the number of `sclk` pulses and the moment `busy` drops, and this shows within one frame. Divider errors show as a high phase of the wrong length at the first pulse. Flag-logic faults show at the end of the frame that should set or keep a flag.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_PLOW,
        ST_PHIGH
    } mlspi_state_t;
endpackage

// File: rtl/mlspi_clkdiv.sv
module mlspi_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mlspi_shifter.sv
module mlspi_shifter #(
    parameter int DW     = 16,
    parameter int LINES  = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              load,
    input  logic [DW-1:0]     load_data,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              last_en,
    input  logic [LINES-1:0]  lines_in,
    output logic [DW-1:0]     word,
    output logic [DW-1:0]     word_last,
    output logic [LINES-1:0]  tops
);
    localparam int NMODES = $clog2(LINES) + 1;

    logic [DW-1:0]                 sreg;
    logic [LINES-1:0]              hold;
    logic [NMODES-1:0][DW-1:0]     sh_hold;
    logic [NMODES-1:0][DW-1:0]     sh_pin;
    logic [NMODES-1:0][LINES-1:0]  tops_m;

    for (genvar m = 0; m < NMODES; m++) begin : g_mode
        localparam int SW = DW >> m;
        for (genvar i = 0; i < DW; i++) begin : g_bit
            if ((i % SW) == 0) begin : g_bot
                assign sh_hold[m][i] = hold[i / SW];
                assign sh_pin[m][i]  = lines_in[i / SW];
            end else begin : g_mid
                assign sh_hold[m][i] = sreg[i - 1];
                assign sh_pin[m][i]  = sreg[i - 1];
            end
        end
        for (genvar k = 0; k < LINES; k++) begin : g_top
            if (k < (1 << m)) begin : g_on
                assign tops_m[m][k] = sreg[k * SW + SW - 1];
            end else begin : g_off
                assign tops_m[m][k] = 1'b0;
            end
        end
    end

    assign word      = sreg;
    assign word_last = sh_pin[mode];
    assign tops      = tops_m[mode];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            hold <= '0;
        end else begin
            if (load) begin
                sreg <= load_data;
            end else if (shift_en) begin
                sreg <= sh_hold[mode];
            end else if (last_en) begin
                sreg <= sh_pin[mode];
            end
            if (cap_en) begin
                hold <= lines_in;
            end
        end
    end
endmodule

// File: rtl/mlspi_engine.sv
module mlspi_engine
    import mlspi_pkg::*;
#(
    parameter int DW     = 16,
    parameter int LINES  = 8,
    parameter int MODE_W = 2,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [DW-1:0]     tx_data,
    input  logic [MODE_W-1:0] lane_mode,
    input  logic              par_en,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [LINES-1:0]  din_lines,
    input  logic              clr_rx,
    input  logic              clr_perr,
    output logic              sclk,
    output logic [LINES-1:0]  dout_lines,
    output logic              busy,
    output logic [DW-1:0]     rx_data,
    output logic              rx_flag,
    output logic              ovr,
    output logic              perr
);
    localparam int BL_W = $clog2(DW) + 1;

    mlspi_state_t      state, state_nx;
    logic [MODE_W-1:0] mode_q;
    logic              par_q, partx_q;
    logic [DIV_W-1:0]  half_q;
    logic [BL_W-1:0]   bits_left;
    logic              tick, last, load, cap_en, shift_en, last_en;
    logic              done_d, done_p;
    logic [DW-1:0]     word, word_last;
    logic [LINES-1:0]  tops;

    mlspi_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .half (half_q),
        .tick (tick)
    );

    mlspi_shifter #(.DW(DW), .LINES(LINES), .MODE_W(MODE_W)) i_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .load     (load),
        .load_data(tx_data),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .last_en  (last_en),
        .lines_in (din_lines),
        .word     (word),
        .word_last(word_last),
        .tops     (tops)
    );

    assign last = (bits_left == BL_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tx_wr) state_nx = ST_SETUP;
            ST_SETUP: if (tick)  state_nx = ST_HIGH;
            ST_HIGH:  if (tick)  state_nx = !last ? ST_LOW : (par_q ? ST_PLOW : ST_IDLE);
            ST_LOW:   if (tick)  state_nx = ST_HIGH;
            ST_PLOW:  if (tick)  state_nx = ST_PHIGH;
            ST_PHIGH: if (tick)  state_nx = ST_IDLE;
            default:             state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath strobes
    always_comb begin
        sclk       = 1'b0;
        busy       = 1'b1;
        dout_lines = '0;
        load       = 1'b0;
        cap_en     = 1'b0;
        shift_en   = 1'b0;
        last_en    = 1'b0;
        done_d     = 1'b0;
        done_p     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = tx_wr;
            end
            ST_SETUP: dout_lines = tops;
            ST_HIGH: begin
                sclk       = 1'b1;
                dout_lines = tops;
                cap_en     = tick && !last;
                last_en    = tick && last;
                done_d     = tick && last && !par_q;
            end
            ST_LOW: begin
                dout_lines = tops;
                shift_en   = tick;
            end
            ST_PLOW:  dout_lines[0] = partx_q;
            ST_PHIGH: begin
                sclk          = 1'b1;
                dout_lines[0] = partx_q;
                done_p        = tick;
            end
            default: busy = 1'b0;
        endcase
    end

    // frame settings, bit counter and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            par_q     <= 1'b0;
            partx_q   <= 1'b0;
            half_q    <= '0;
            bits_left <= '0;
            rx_data   <= '0;
            rx_flag   <= 1'b0;
            ovr       <= 1'b0;
            perr      <= 1'b0;
        end else begin
            if (load) begin
                mode_q    <= lane_mode;
                par_q     <= par_en;
                partx_q   <= ^tx_data;
                half_q    <= half_div;
                bits_left <= BL_W'(DW >> lane_mode);
            end else if (cap_en) begin
                bits_left <= bits_left - 1'b1;
            end

            if (done_d) begin
                rx_data <= word_last;
            end else if (done_p) begin
                rx_data <= word;
            end

            if (done_d || done_p) begin
                rx_flag <= 1'b1;
            end else if (clr_rx) begin
                rx_flag <= 1'b0;
            end

            if ((done_d || done_p) && rx_flag && !clr_rx) begin
                ovr <= 1'b1;
            end else if (clr_rx) begin
                ovr <= 1'b0;
            end

            if (done_p && ((^word) != din_lines[0])) begin
                perr <= 1'b1;
            end else if (clr_perr) begin
                perr <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mlspi_checker.sv
module mlspi_checker #(
    parameter int LINES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sclk,
    input logic [LINES-1:0] dout_lines,
    input logic             rx_flag,
    input logic             clr_rx,
    input logic             ovr,
    input logic             perr,
    input logic             clr_perr
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R1

    AST_IDLE_LINES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dout_lines == '0)); // R1

    AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(dout_lines)); // R4

    AST_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !sclk && !$past(sclk)) |-> $stable(dout_lines)); // R4

    AST_RX_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !clr_rx) |=> rx_flag); // R7

    AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rx_flag)); // R8

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !clr_perr) |=> perr); // R10
endmodule

bind mlspi_engine mlspi_checker #(.LINES(LINES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sclk      (sclk),
    .dout_lines(dout_lines),
    .rx_flag   (rx_flag),
    .clr_rx    (clr_rx),
    .ovr       (ovr),
    .perr      (perr),
    .clr_perr  (clr_perr)
);

// File: tb/test_mlspi_engine.sv
module test_mlspi_engine;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tx_wr = 0;
    logic [15:0] tx_data = '0;
    logic [1:0]  lane_mode = '0;
    logic        par_en = 0;
    logic [7:0]  half_div = '0;
    logic [7:0]  din_lines = '0;
    logic        clr_rx = 0;
    logic        clr_perr = 0;
    logic        sclk;
    logic [7:0]  dout_lines;
    logic        busy;
    logic [15:0] rx_data;
    logic        rx_flag, ovr, perr;

    int checks = 0;
    int errors = 0;
    bit exp_rxf = 0, exp_ovr = 0, exp_perr = 0;

    always #(CLK_P / 2) clk = ~clk;

    mlspi_engine i_mlspi_engine (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data),
        .lane_mode(lane_mode), .par_en(par_en), .half_div(half_div),
        .din_lines(din_lines), .clr_rx(clr_rx), .clr_perr(clr_perr),
        .sclk(sclk), .dout_lines(dout_lines), .busy(busy), .rx_data(rx_data),
        .rx_flag(rx_flag), .ovr(ovr), .perr(perr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_out(input int md, input logic [15:0] w, input int r);
        int nl = 1 << md;
        int sw = 16 / nl;
        logic [7:0] v = '0;
        for (int k = 0; k < nl; k++) v[k] = w[k * sw + sw - 1 - r];
        return v;
    endfunction

    task automatic run_frame(input int md, input bit pe, input logic [15:0] tx,
                             input logic [15:0] sv, input int hd, input bit bad_par, input bit poke);
        int nl = 1 << md;
        int sw = 16 / nl;
        int rises = 0, bad_d = 0, bad_p = 0, bad_s = 0, hi = 0, hi_bad = 0, guard = 0;
        bit prev = 0;
        logic [7:0] e;
        lane_mode = 2'(md); par_en = pe; half_div = 8'(hd); tx_data = tx;
        din_lines = exp_out(md, sv, 0);
        tx_wr = 1;
        @(negedge clk);
        tx_wr = 0;
        while (busy && guard < 5000) begin
            tx_wr = 0;
            if (sclk && !prev) begin
                if (rises < sw) begin
                    e = exp_out(md, tx, rises);
                    if (dout_lines !== e) bad_d++;
                    din_lines = exp_out(md, sv, rises) | (8'($urandom) & ~8'((1 << nl) - 1));
                end else begin
                    e = {7'b0, ^tx};
                    if (dout_lines !== e) bad_p++;
                    din_lines = {7'($urandom), (^sv) ^ bad_par};
                end
                if (poke && rises == 0) begin
                    tx_wr = 1; tx_data = ~tx; lane_mode = 2'(md ^ 1);
                    par_en = !pe; half_div = 8'(hd + 1);
                end
                hi = 0;
                rises++;
            end
            if (!sclk && rises == 0 && dout_lines !== exp_out(md, tx, 0)) bad_s++;
            if (sclk) hi++;
            if (!sclk && prev && hi != hd + 1) hi_bad++;
            prev = sclk;
            @(negedge clk);
            guard++;
        end
        tx_wr = 0;
        if (prev && hi != hd + 1) hi_bad++;
        exp_ovr = exp_ovr | exp_rxf;
        exp_rxf = 1;
        exp_perr = exp_perr | (pe & bad_par);
        chk(rises == sw + int'(pe), "R2 sclk pulse count", rises, sw + int'(pe));
        chk(bad_d == 0, "R3 data line values", bad_d, 0);
        chk(bad_s == 0, "R4 first bits before first rise", bad_s, 0);
        chk(hi_bad == 0, "R6 high phase length", hi_bad, 0);
        chk(rx_data == sv, "R5 received word", rx_data, sv);
        chk(rx_flag == exp_rxf, "R7 receive flag", rx_flag, exp_rxf);
        chk(ovr == exp_ovr, "R8 overrun flag", ovr, exp_ovr);
        if (pe) chk(bad_p == 0, "R9 parity pulse lines", bad_p, 0);
        chk(perr == exp_perr, "R10 parity error flag", perr, exp_perr);
        if (poke) chk(bad_d == 0 && rises == sw + int'(pe), "R11 write while busy ignored", rises, sw + int'(pe));
    endtask

    task automatic clear_rx();
        @(negedge clk); clr_rx = 1;
        @(negedge clk); clr_rx = 0;
        exp_rxf = 0; exp_ovr = 0;
        chk(rx_flag == 0 && ovr == 0, "R7 clear of receive and overrun flags", {rx_flag, ovr}, 0);
    endtask

    task automatic clear_perr();
        @(negedge clk); clr_perr = 1;
        @(negedge clk); clr_perr = 0;
        exp_perr = 0;
        chk(perr == 0, "R10 parity error cleared", perr, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        checks++; errors++;
        $display("FAIL R7 watchdog actual=hung expected=frame end");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        chk(sclk == 0 && dout_lines == 0 && busy == 0, "R1 reset lines", {sclk, busy, dout_lines}, 0);
        chk(rx_data == 0 && rx_flag == 0 && ovr == 0 && perr == 0, "R1 reset flags", {rx_data, rx_flag, ovr, perr}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(sclk == 0 && busy == 0, "R1 idle after reset", {sclk, busy}, 0);

        // directed: 8 lines, fastest clock
        run_frame(3, 0, 16'hA55A, 16'h3C96, 0, 0, 0);
        clear_rx();
        // 1 line with parity
        run_frame(0, 1, 16'h8001, 16'hFFFE, 1, 0, 0);
        // overrun: no clear between frames (R8)
        run_frame(1, 0, 16'h1234, 16'hCAFE, 2, 0, 0);
        clear_rx();
        // bad parity on 4 lines, then sticky check (R10)
        run_frame(2, 1, 16'h0F0F, 16'h7001, 0, 1, 0);
        clear_rx();
        run_frame(3, 1, 16'hFFFF, 16'h0000, 1, 0, 0);
        clear_rx();
        clear_perr();
        // write and setting changes while busy (R11)
        run_frame(2, 0, 16'hBEEF, 16'h5AA5, 3, 0, 1);
        clear_rx();
        run_frame(3, 1, 16'h6789, 16'h9876, 2, 0, 1);
        clear_rx();

        for (int n = 0; n < 40; n++) begin
            run_frame($urandom_range(0, 3), 1'($urandom), 16'($urandom), 16'($urandom),
                      $urandom_range(0, 3), 1'($urandom), 0);
            if ($urandom_range(0, 3) != 0) clear_rx();
            if (exp_perr && $urandom_range(0, 1) == 1) clear_perr();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule